// File: doc/BRIEF.md
# Multidrop Address-Wake Serial Receiver

This block receives asynchronous serial frames on a multidrop line where several stations share one wire. Each frame has a start bit at 0, eight data bits sent least significant bit first, one extra address-mark bit and a stop bit at 1. When the address-mark bit is 1, the frame carries a station ID. When it is 0, the frame carries data. The line rests at logic 1 between frames. The receiver samples the line on a tick that runs at sixteen times the bit rate. It confirms a start bit at the middle sample of that bit and samples every later bit at its centre.

Software arms a wake flag with a one-cycle strobe. While the flag is armed, every frame with a 0 address mark is dropped without a trace. The first frame with a 1 address mark is delivered: the byte goes to the data register, the full flag is set and the interrupt is raised. The same frame disarms the wake flag on its own, so the data frames that follow are accepted. If the delivered ID does not belong to this station, software re-arms the flag and skipping resumes. A read strobe tells the block that software has taken the byte.

The receive state machine has six states:
- `ST_IDLE` waits for a low sample.
- `ST_START` confirms the start bit at mid-bit, or falls back to `ST_IDLE` on a glitch.
- `ST_DATA` collects the eight data bits.
- `ST_MPB` samples the address mark.
- `ST_STOP` samples the stop bit and hands the frame over. A high stop bit leads to `ST_IDLE`; a low stop bit leads to `ST_BREAK`.
- `ST_BREAK` waits for the line to go high again, then returns to `ST_IDLE`.

Top module: `mdrop_rx`

## Requirements
- R1: A frame is one low start bit, eight data bits (first bit on the wire is data bit 0), one address-mark bit and a high stop bit. With the wake flag clear, every frame is delivered to `data_o`.
- R2: While the line stays high, no frame is received: `full_o` stays 0 and `data_o` does not change.
- R3: While `wake_o` is 1, a frame whose address mark is 0 leaves `data_o`, `full_o`, `mpb_o` and `irq_o` unchanged, and `wake_o` stays 1.
- R4: While `wake_o` is 1, a frame whose address mark is 1 loads its byte into `data_o`, sets `full_o` and sets `mpb_o` to 1.
- R5: A frame with address mark 1 clears `wake_o` to 0. After that, frames are delivered whatever their address mark.
- R6: A pulse on `rd_clr_i` clears `full_o`, `ovr_o` and `ferr_o`. A pulse on `wake_set_i` sets `wake_o` at any time, and it takes priority over a clear in the same cycle.
- R7: The receiver samples at 16 ticks per bit. A low pulse shorter than half a bit is rejected as a false start, and the receiver stays idle.
- R8: A stop bit sampled low sets `ferr_o`. The frame is still delivered or dropped by the rule of R3/R4/R5. The receiver then waits for the line to go high before it looks for a new start bit.
- R9: A frame that would be delivered while `full_o` is 1 leaves `data_o` unchanged and sets `ovr_o`.
- R10: `irq_o` is 1 exactly when `full_o` is 1 and `irq_en_i` is 1.
- R11: `mpb_o` shows the address-mark bit of the last frame loaded into `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idles high |
| tick16_i | input | 1 | Sample enable at 16x the bit rate |
| wake_set_i | input | 1 | One-cycle strobe that arms the wake flag |
| rd_clr_i | input | 1 | One-cycle strobe: byte taken, clears the full, overrun and framing flags |
| irq_en_i | input | 1 | Receive interrupt enable |
| data_o | output | 8 | Received byte register |
| mpb_o | output | 1 | Address mark of the last delivered frame |
| full_o | output | 1 | Receive register holds an unread byte |
| wake_o | output | 1 | Wake flag: skipping frames with address mark 0 |
| ferr_o | output | 1 | Framing error seen |
| ovr_o | output | 1 | Overrun: a frame was lost because the register was full |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The assertions check the following rules on every cycle:
- A dropped frame leaves the data register and the full flag alone.
- A delivered ID frame sets the full flag and clears the wake flag.
- A delivery into a full register keeps the old byte and sets the overrun flag.
- A low stop bit sets the framing flag.
- The state machine stays idle on a high line and falls back to idle on a false start.

Only the bench scenarios can show the following:
- The bit order and the sampling points, through the full byte sweep.
- The full sequence of skipping data frames, waking on an ID and then accepting data.
- The rejection of a short low glitch.
- The interaction of the interrupt enable with the full flag.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP,
        ST_BREAK
    } rx_state_e;
endpackage

// File: rtl/mdrop_sync.sv
module mdrop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdrop_frame.sv
module mdrop_frame
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              line_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              mpb_o,
    output logic              stop_ok_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              mpb_q;
    logic              at_mid, at_end;

    assign at_mid = tick_i && (cnt_q == MID);
    assign at_end = tick_i && (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick_i && !line_i) state_d = ST_START;
            ST_START: if (at_mid) state_d = line_i ? ST_IDLE : ST_DATA;
            ST_DATA:  if (at_end && idx_q == TOP) state_d = ST_MPB;
            ST_MPB:   if (at_end) state_d = ST_STOP;
            ST_STOP:  if (at_end) state_d = line_i ? ST_IDLE : ST_BREAK;
            ST_BREAK: if (line_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shift_q   <= '0;
            mpb_q     <= 1'b0;
            done_o    <= 1'b0;
            data_o    <= '0;
            mpb_o     <= 1'b0;
            stop_ok_o <= 1'b1;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= CNT_W'(1);
                    idx_q <= '0;
                end
                ST_START: begin
                    if (at_mid)      cnt_q <= '0;
                    else if (tick_i) cnt_q <= cnt_q + 1'b1;
                end
                ST_DATA: begin
                    if (at_end) begin
                        cnt_q   <= '0;
                        shift_q <= {line_i, shift_q[DATA_W-1:1]};
                        idx_q   <= idx_q + 1'b1;
                    end else if (tick_i) cnt_q <= cnt_q + 1'b1;
                end
                ST_MPB: begin
                    if (at_end) begin
                        cnt_q <= '0;
                        mpb_q <= line_i;
                    end else if (tick_i) cnt_q <= cnt_q + 1'b1;
                end
                ST_STOP: begin
                    if (at_end) begin
                        done_o    <= 1'b1;
                        data_o    <= shift_q;
                        mpb_o     <= mpb_q;
                        stop_ok_o <= line_i;
                    end else if (tick_i) cnt_q <= cnt_q + 1'b1;
                end
                ST_BREAK: cnt_q <= '0;
                default:  cnt_q <= '0;
            endcase
        end
    end

    // R2: a high line keeps the machine idle
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && line_i) |=> (state_q == ST_IDLE));
    // R7: a start that is high at mid-bit is rejected
    a_r7_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && at_mid && line_i) |=> (state_q == ST_IDLE && !done_o));
    // R8: after a low stop bit, wait for the line to go high
    a_r8_break_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BREAK && !line_i) |=> (state_q == ST_BREAK));
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              tick16_i,
    input  logic              wake_set_i,
    input  logic              rd_clr_i,
    input  logic              irq_en_i,
    output logic [DATA_W-1:0] data_o,
    output logic              mpb_o,
    output logic              full_o,
    output logic              wake_o,
    output logic              ferr_o,
    output logic              ovr_o,
    output logic              irq_o
);
    logic              line_s;
    logic              fr_done, fr_mpb, fr_stop_ok;
    logic [DATA_W-1:0] fr_data;
    logic              deliver, full_eff;

    mdrop_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rxd_i),
        .sync_o  (line_s)
    );

    mdrop_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick16_i),
        .line_i    (line_s),
        .done_o    (fr_done),
        .data_o    (fr_data),
        .mpb_o     (fr_mpb),
        .stop_ok_o (fr_stop_ok)
    );

    assign deliver  = fr_done && (!wake_o || fr_mpb);
    assign full_eff = full_o && !rd_clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            mpb_o  <= 1'b0;
            full_o <= 1'b0;
            wake_o <= 1'b0;
            ferr_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            if (rd_clr_i) begin
                full_o <= 1'b0;
                ovr_o  <= 1'b0;
                ferr_o <= 1'b0;
            end
            if (fr_done && !fr_stop_ok) ferr_o <= 1'b1;
            if (fr_done && fr_mpb) wake_o <= 1'b0;
            if (deliver) begin
                if (full_eff) ovr_o <= 1'b1;
                else begin
                    data_o <= fr_data;
                    mpb_o  <= fr_mpb;
                    full_o <= 1'b1;
                end
            end
            if (wake_set_i) wake_o <= 1'b1;
        end
    end

    assign irq_o = full_o && irq_en_i;

    // R3: a skipped data frame changes nothing
    a_r3_skip_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && wake_o && !fr_mpb && !rd_clr_i) |=> ($stable(data_o) && $stable(full_o) && $stable(mpb_o)));
    // R4: an ID frame into an empty register sets full and the mark
    a_r4_id_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && wake_o && fr_mpb && !full_o) |=> (full_o && mpb_o));
    // R5: an ID frame drops the wake flag
    a_r5_wake_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && fr_mpb && !wake_set_i) |=> !wake_o);
    // R9: delivery into a full register keeps the byte and flags overrun
    a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && full_o && !rd_clr_i) |=> (ovr_o && $stable(data_o)));
    // R8: a low stop bit raises the framing flag
    a_r8_ferr: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && !fr_stop_ok) |=> ferr_o);
endmodule

// File: tb/sim_mdrop_rx.sv
module sim_mdrop_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b1;
    logic       wset = 1'b0;
    logic       rclr = 1'b0;
    logic       ien = 1'b0;
    logic [7:0] data;
    logic       mpb, full, wake, ferr, ovr, irq;
    int         total = 0;
    int         bad = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    mdrop_rx u0 (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick16_i(tick),
        .wake_set_i(wset), .rd_clr_i(rclr), .irq_en_i(ien),
        .data_o(data), .mpb_o(mpb), .full_o(full), .wake_o(wake),
        .ferr_o(ferr), .ovr_o(ovr), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic m, input logic s);
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (16) @(negedge clk);
        end
        rxd = m;
        repeat (16) @(negedge clk);
        rxd = s;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic pulse_clr();
        rclr = 1'b1; @(negedge clk); rclr = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_wake();
        wset = 1'b1; @(negedge clk); wset = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 reset data", int'(data), 0);
        chk("R1 reset full", int'(full), 0);
        chk("R5 reset wake", int'(wake), 0);
        chk("R8 reset ferr", int'(ferr), 0);
        chk("R9 reset ovr", int'(ovr), 0);
        chk("R10 reset irq", int'(irq), 0);

        // R2: idle line
        repeat (200) @(negedge clk);
        chk("R2 idle full", int'(full), 0);
        chk("R2 idle data", int'(data), 0);

        // R1/R11/R10: full byte sweep, mark computed from the byte
        ien = 1'b1;
        for (int b = 0; b < 256; b++) begin
            logic m;
            m = b[0] ^ b[7];
            send(8'(b), m, 1'b1);
            chk("R1 byte", int'(data), b);
            chk("R1 full", int'(full), 1);
            chk("R11 mark", int'(mpb), int'(m));
            chk("R10 irq on", int'(irq), 1);
            pulse_clr();
            chk("R6 clr full", int'(full), 0);
        end

        // R3: armed, data frame skipped
        pulse_wake();
        chk("R6 wake set", int'(wake), 1);
        send(8'h55, 1'b0, 1'b1);
        chk("R3 data kept", int'(data), 255);
        chk("R3 full kept", int'(full), 0);
        chk("R3 irq low", int'(irq), 0);
        chk("R3 wake kept", int'(wake), 1);

        // R4/R5: ID frame delivered, wake drops
        send(8'h3C, 1'b1, 1'b1);
        chk("R4 id data", int'(data), 8'h3C);
        chk("R4 id full", int'(full), 1);
        chk("R4 id mark", int'(mpb), 1);
        chk("R5 wake cleared", int'(wake), 0);
        ien = 1'b0;
        @(negedge clk);
        chk("R10 irq masked", int'(irq), 0);
        ien = 1'b1;
        pulse_clr();

        // R5: data after wake accepted
        send(8'hA7, 1'b0, 1'b1);
        chk("R5 data after id", int'(data), 8'hA7);
        chk("R11 data mark", int'(mpb), 0);

        // R9: overrun
        send(8'h12, 1'b0, 1'b1);
        chk("R9 data kept", int'(data), 8'hA7);
        chk("R9 ovr set", int'(ovr), 1);
        chk("R9 full kept", int'(full), 1);
        pulse_clr();
        chk("R6 ovr cleared", int'(ovr), 0);

        // R8: framing error, delivered then skipped
        send(8'h81, 1'b0, 1'b0);
        chk("R8 ferr", int'(ferr), 1);
        chk("R8 data delivered", int'(data), 8'h81);
        pulse_clr();
        chk("R6 ferr cleared", int'(ferr), 0);
        pulse_wake();
        send(8'h99, 1'b0, 1'b0);
        chk("R8 ferr skip", int'(ferr), 1);
        chk("R8 skip full", int'(full), 0);
        chk("R8 skip data", int'(data), 8'h81);
        send(8'h6E, 1'b1, 1'b1);
        chk("R8 recovers", int'(data), 8'h6E);
        pulse_clr();

        // R7: short glitch rejected
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk("R7 glitch full", int'(full), 0);
        chk("R7 glitch data", int'(data), 8'h6E);
        send(8'hC3, 1'b0, 1'b1);
        chk("R7 after glitch", int'(data), 8'hC3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule